// File: doc/BRIEF.md
# SMBus Block-Read Master Sequencer

This block is the master-side controller for a single SMBus/PMBus Block Read. Firmware places the command code on `tx_cmd`, sets the 7-bit target address, the number of data bytes it expects and whether a packet-error-check byte follows. It then pulses `start`. The sequencer steps through the whole transaction on a byte-level bus-primitive interface: start, address write, command, repeated start, address read, a string of byte receives, and stop. A separate bit-level engine that drives SCL and SDA carries out each primitive.

Every received byte is packed into a 32-bit receive word. This includes the length byte the target sends first and, when enabled, the trailing check byte. Each time four bytes fill the word, the block raises a data-ready flag and pauses the bus until firmware acknowledges it. When stop completes, the block raises end-of-message and reports how many bytes the final word holds. The master acknowledges every byte except the final one of the message. That final byte is the last data byte without PEC, or the PEC byte with it.

If the target refuses an address or the command, the sequencer issues stop at once and sets an error flag together with end-of-message.

Top module: `smb_blkrd_master`

## Requirements
- R1: After an accepted `start`, the primitives issued on `prim_op` are, in order: START (0), SEND (2) of `{addr,0}`, SEND of the command byte, RSTART (1), SEND of `{addr,1}`, then T = N+1+PEC RECV (3) operations, then STOP (4). N is `byte_count` and PEC is `pec_en`, both captured at start.
- R2: With `pec_en`=0, `prim_ack` is 1 (ACK) on every RECV except the last of the T receives, where it is 0 (NACK). When N=0, the NACK falls on the length byte itself.
- R3: With `pec_en`=1, one extra RECV follows the N data bytes. Only that extra byte is NACKed, and it is stored like a data byte.
- R4: Received bytes are packed little-endian: the first byte of a word goes in bits 7:0 and the fourth in bits 31:24. The length byte is the first byte of the first word. Lanes not yet written in the current word read as zero.
- R5: `data_ready` rises when a non-final byte completes a word. It stays high until `dr_clear`, and no further RECV is requested while it is high.
- R6: `eom` rises in the cycle after STOP completes and holds until the next accepted start. If the final byte completed a word, `data_ready` rises in that same cycle (for example, N=3 with no PEC).
- R7: At `eom`, `rx_count` equals T mod 4, where 0 means four valid bytes. After an error it reads 0.
- R8: A NACK from the target on either address or on the command byte causes STOP to be the next primitive, with no RECV. `err` and `eom` are both set.
- R9: A `start` pulse while `busy` is ignored. Inputs changed after start do not alter the running transaction. An accepted start clears `eom`, `err` and `data_ready`.
- R10: Once `prim_valid` is raised, it and `prim_op`, `prim_wdata` and `prim_ack` hold steady until the cycle `prim_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (pulse) |
| slave_addr | input | 7 | Target address |
| tx_cmd | input | 8 | Command byte from the transmit register |
| byte_count | input | 8 | Number of data bytes N |
| pec_en | input | 1 | Expect a trailing check byte |
| dr_clear | input | 1 | Firmware acknowledge of data-ready |
| prim_valid | output | 1 | Primitive request |
| prim_op | output | 3 | Primitive code: 0 START, 1 RSTART, 2 SEND, 3 RECV, 4 STOP |
| prim_wdata | output | 8 | Byte for SEND |
| prim_ack | output | 1 | For RECV: 1 = ACK, 0 = NACK |
| prim_done | input | 1 | Primitive finished (one-cycle pulse) |
| prim_nack | input | 1 | Target NACKed the SEND, valid with prim_done |
| prim_rdata | input | 8 | Byte received, valid with prim_done |
| rx_word | output | 32 | Packed receive word |
| rx_count | output | 2 | Valid bytes in final word (0 = 4) |
| data_ready | output | 1 | Word of four bytes ready |
| eom | output | 1 | End of message |
| err | output | 1 | Target refused address or command |
| busy | output | 1 | Transaction in progress |

## Verification
The hardest situation to reach is the data-ready hold: the bus must stay paused while firmware leaves a full word unacknowledged. This must be told apart from the end case, where the last byte closes a word and data-ready must coincide with end-of-message instead of pausing. The stimulus reaches both by mixing random block lengths (0 to 40, with and without PEC) with random firmware response delays and random bus latencies. It adds directed totals of exactly 4 and 8 bytes. The bus model flags any receive requested while data-ready is high. Directed runs also inject a NACK at each of the three send phases and pulse start mid-transaction with changed inputs.

// File: rtl/smb_blkrd_pkg.sv
package smb_blkrd_pkg;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_SEND   = 3'd2,
    OP_RECV   = 3'd3,
    OP_STOP   = 3'd4
  } bus_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START,
    S_ADDRW,
    S_CMD,
    S_RSTART,
    S_ADDRR,
    S_RECV,
    S_HOLD,
    S_STOP
  } seq_state_e;

endpackage

// File: rtl/smb_blkrd_fsm.sv
module smb_blkrd_fsm
  import smb_blkrd_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BYTE_W-1:0] cmd_in,
  input  logic [CNT_W-1:0]  count_in,
  input  logic              pec_in,
  input  logic              prim_done,
  input  logic              prim_nack,
  input  logic              word_fill,
  input  logic              dr_pending,
  output logic              prim_valid,
  output bus_op_e           prim_op,
  output logic [BYTE_W-1:0] prim_wdata,
  output logic              prim_ack,
  output logic              busy,
  output logic              start_ok,
  output logic              rx_push,
  output logic              rx_last,
  output logic              finish,
  output logic              nack_seen
);

  localparam int IDX_W = CNT_W + 2;

  seq_state_e        state_q, nxt;
  bus_op_e           nxt_op;
  logic [BYTE_W-1:0] nxt_wdata;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] cmd_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  last_q;
  logic              nacked_q;
  logic              send_refused;

  assign start_ok     = start && (state_q == S_IDLE);
  assign busy         = (state_q != S_IDLE);
  assign rx_push      = (state_q == S_RECV) && prim_done;
  assign rx_last      = (idx_q == last_q);
  assign finish       = (state_q == S_STOP) && prim_done;
  assign nack_seen    = nacked_q;
  assign prim_ack     = (idx_q != last_q);
  assign send_refused = prim_done && prim_nack;

  always_comb begin
    nxt = state_q;
    case (state_q)
      S_IDLE:   if (start) nxt = S_START;
      S_START:  if (prim_done) nxt = S_ADDRW;
      S_ADDRW:  if (prim_done) nxt = send_refused ? S_STOP : S_CMD;
      S_CMD:    if (prim_done) nxt = send_refused ? S_STOP : S_RSTART;
      S_RSTART: if (prim_done) nxt = S_ADDRR;
      S_ADDRR:  if (prim_done) nxt = send_refused ? S_STOP : S_RECV;
      S_RECV: begin
        if (prim_done) begin
          if (rx_last)        nxt = S_STOP;
          else if (word_fill) nxt = S_HOLD;
          else                nxt = S_RECV;
        end
      end
      S_HOLD:   if (!dr_pending) nxt = S_RECV;
      S_STOP:   if (prim_done) nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_comb begin
    nxt_op    = OP_STOP;
    nxt_wdata = '0;
    case (nxt)
      S_START:  nxt_op = OP_START;
      S_ADDRW: begin
        nxt_op    = OP_SEND;
        nxt_wdata = BYTE_W'({addr_q, 1'b0});
      end
      S_CMD: begin
        nxt_op    = OP_SEND;
        nxt_wdata = cmd_q;
      end
      S_RSTART: nxt_op = OP_RSTART;
      S_ADDRR: begin
        nxt_op    = OP_SEND;
        nxt_wdata = BYTE_W'({addr_q, 1'b1});
      end
      S_RECV:   nxt_op = OP_RECV;
      default:  nxt_op = OP_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      prim_valid <= 1'b0;
      prim_op    <= OP_STOP;
      prim_wdata <= '0;
    end else begin
      state_q    <= nxt;
      prim_valid <= (nxt != S_IDLE) && (nxt != S_HOLD);
      prim_op    <= nxt_op;
      prim_wdata <= nxt_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      cmd_q    <= '0;
      idx_q    <= '0;
      last_q   <= '0;
      nacked_q <= 1'b0;
    end else if (start_ok) begin
      addr_q   <= addr_in;
      cmd_q    <= cmd_in;
      idx_q    <= '0;
      last_q   <= IDX_W'(count_in) + IDX_W'(pec_in);
      nacked_q <= 1'b0;
    end else begin
      if (send_refused && ((state_q == S_ADDRW) || (state_q == S_CMD) ||
                           (state_q == S_ADDRR)))
        nacked_q <= 1'b1;
      if (rx_push)
        idx_q <= idx_q + 1'b1;
    end
  end

  // R10: a request holds still until it is completed
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    prim_valid && !prim_done |=> prim_valid && $stable(prim_op) &&
      $stable(prim_wdata) && $stable(prim_ack));

  // R8: after a refused send only STOP may be requested
  assert_stop_after_nack_R8: assert property (@(posedge clk) disable iff (rst)
    nack_seen && prim_valid |-> prim_op == OP_STOP);

  // R1: a started transaction opens with START
  assert_open_with_start_R1: assert property (@(posedge clk) disable iff (rst)
    start_ok |=> prim_valid && prim_op == OP_START);

endmodule

// File: rtl/smb_rx_packer.sv
module smb_rx_packer #(
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clear,
  input  logic                          push,
  input  logic [BYTE_W-1:0]             din,
  output logic [BYTE_W*WORD_BYTES-1:0]  word,
  output logic [$clog2(WORD_BYTES)-1:0] lane,
  output logic                          word_fill
);

  localparam int LANE_W = $clog2(WORD_BYTES);
  localparam int WORD_W = BYTE_W * WORD_BYTES;

  logic [LANE_W-1:0] lane_q;

  assign lane      = lane_q;
  assign word_fill = (lane_q == LANE_W'(WORD_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst || clear)
      lane_q <= '0;
    else if (push)
      lane_q <= lane_q + 1'b1;
  end

  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
    logic [BYTE_W-1:0] b_q;
    always_ff @(posedge clk) begin
      if (rst || clear)
        b_q <= '0;
      else if (push) begin
        if (lane_q == LANE_W'(i))
          b_q <= din;
        else if (lane_q == '0)
          b_q <= '0;
      end
    end
    assign word[i*BYTE_W +: BYTE_W] = b_q;
  end

  // R4: the first byte of a word lands low and the rest of the word is zero
  assert_first_lane_R4: assert property (@(posedge clk) disable iff (rst)
    push && !clear && lane_q == '0 |=>
      (word[BYTE_W-1:0] == $past(din)) && (word[WORD_W-1:BYTE_W] == '0));

endmodule

// File: rtl/smb_irq_ctrl.sv
module smb_irq_ctrl #(
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_ok,
  input  logic              push,
  input  logic              push_last,
  input  logic              word_fill,
  input  logic              finish,
  input  logic              nack_in,
  input  logic              dr_clear,
  input  logic [LANE_W-1:0] lane,
  output logic              data_ready,
  output logic              eom,
  output logic [LANE_W-1:0] rx_count,
  output logic              err
);

  logic final_full_q;

  always_ff @(posedge clk) begin
    if (rst || start_ok)
      final_full_q <= 1'b0;
    else if (push && push_last)
      final_full_q <= word_fill;
  end

  always_ff @(posedge clk) begin
    if (rst || start_ok)
      data_ready <= 1'b0;
    else if (push && word_fill && !push_last)
      data_ready <= 1'b1;
    else if (finish && final_full_q)
      data_ready <= 1'b1;
    else if (dr_clear)
      data_ready <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || start_ok) begin
      eom      <= 1'b0;
      err      <= 1'b0;
      rx_count <= '0;
    end else if (finish) begin
      eom      <= 1'b1;
      err      <= nack_in;
      rx_count <= nack_in ? '0 : lane;
    end
  end

  // R8: an error is always reported together with end of message
  assert_err_with_eom_R8: assert property (@(posedge clk) disable iff (rst)
    err |-> eom);

  // R6: end of message appears only when a stop completes
  assert_eom_on_finish_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(eom) |-> $past(finish));

endmodule

// File: rtl/smb_blkrd_master.sv
module smb_blkrd_master
  import smb_blkrd_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int BYTE_W     = 8,
  parameter int CNT_W      = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [ADDR_W-1:0]             slave_addr,
  input  logic [BYTE_W-1:0]             tx_cmd,
  input  logic [CNT_W-1:0]              byte_count,
  input  logic                          pec_en,
  input  logic                          dr_clear,
  output logic                          prim_valid,
  output logic [2:0]                    prim_op,
  output logic [BYTE_W-1:0]             prim_wdata,
  output logic                          prim_ack,
  input  logic                          prim_done,
  input  logic                          prim_nack,
  input  logic [BYTE_W-1:0]             prim_rdata,
  output logic [BYTE_W*WORD_BYTES-1:0]  rx_word,
  output logic [$clog2(WORD_BYTES)-1:0] rx_count,
  output logic                          data_ready,
  output logic                          eom,
  output logic                          err,
  output logic                          busy
);

  localparam int LANE_W = $clog2(WORD_BYTES);

  bus_op_e           op_w;
  logic              start_ok, rx_push, rx_last, finish, nack_seen, word_fill;
  logic [LANE_W-1:0] lane;

  assign prim_op = op_w;

  smb_blkrd_fsm #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start),
    .addr_in(slave_addr), .cmd_in(tx_cmd), .count_in(byte_count),
    .pec_in(pec_en), .prim_done(prim_done), .prim_nack(prim_nack),
    .word_fill(word_fill), .dr_pending(data_ready),
    .prim_valid(prim_valid), .prim_op(op_w), .prim_wdata(prim_wdata),
    .prim_ack(prim_ack), .busy(busy), .start_ok(start_ok),
    .rx_push(rx_push), .rx_last(rx_last), .finish(finish),
    .nack_seen(nack_seen)
  );

  smb_rx_packer #(
    .BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)
  ) u_pack (
    .clk(clk), .rst(rst), .clear(start_ok), .push(rx_push),
    .din(prim_rdata), .word(rx_word), .lane(lane), .word_fill(word_fill)
  );

  smb_irq_ctrl #(
    .LANE_W(LANE_W)
  ) u_irq (
    .clk(clk), .rst(rst), .start_ok(start_ok), .push(rx_push),
    .push_last(rx_last), .word_fill(word_fill), .finish(finish),
    .nack_in(nack_seen), .dr_clear(dr_clear), .lane(lane),
    .data_ready(data_ready), .eom(eom), .rx_count(rx_count), .err(err)
  );

  // R5: no byte is requested while a full word waits for firmware
  assert_hold_on_ready_R5: assert property (@(posedge clk) disable iff (rst)
    prim_valid && prim_op == OP_RECV |-> !data_ready);

  // R6: end of message is only shown once the bus is released
  assert_eom_idle_R6: assert property (@(posedge clk) disable iff (rst)
    eom |-> !busy);

  // R9: a start while busy leaves the bus request running
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
    busy && start && !prim_done |=> busy && $stable(prim_op));

endmodule

// File: tb/smb_blkrd_master_test.sv
module smb_blkrd_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int LOG_N      = 80;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [6:0]  slave_addr = '0;
  logic [7:0]  tx_cmd = '0;
  logic [7:0]  byte_count = '0;
  logic        pec_en = 1'b0;
  logic        dr_clear = 1'b0;
  logic        prim_valid;
  logic [2:0]  prim_op;
  logic [7:0]  prim_wdata;
  logic        prim_ack;
  logic        prim_done = 1'b0;
  logic        prim_nack = 1'b0;
  logic [7:0]  prim_rdata = '0;
  logic [31:0] rx_word;
  logic [1:0]  rx_count;
  logic        data_ready, eom, err, busy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [2:0] op_log  [LOG_N];
  logic [7:0] dat_log [LOG_N];
  logic       ack_log [LOG_N];
  int n_ops, send_i, rcv_i;
  int nack_at = -1;
  int cur_n = 0;
  int cur_salt = 0;

  smb_blkrd_master uut (
    .clk(clk), .rst(rst), .start(start), .slave_addr(slave_addr),
    .tx_cmd(tx_cmd), .byte_count(byte_count), .pec_en(pec_en),
    .dr_clear(dr_clear), .prim_valid(prim_valid), .prim_op(prim_op),
    .prim_wdata(prim_wdata), .prim_ack(prim_ack), .prim_done(prim_done),
    .prim_nack(prim_nack), .prim_rdata(prim_rdata), .rx_word(rx_word),
    .rx_count(rx_count), .data_ready(data_ready), .eom(eom), .err(err),
    .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int i);
    if (i == 0) return 8'(cur_n);
    return 8'(cur_salt + i * 37 + (i >> 2));
  endfunction

  function automatic logic [31:0] exp_word(input int k, input int total);
    logic [31:0] w = '0;
    for (int b = 0; b < 4; b++)
      if (4 * k + b < total) w[b*8 +: 8] = exp_byte(4 * k + b);
    return w;
  endfunction

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // bus primitive model with target behaviour
  initial begin
    forever begin
      @(negedge clk);
      if (prim_valid) begin
        logic [2:0] op;
        op = prim_op;
        if (n_ops < LOG_N) begin
          op_log[n_ops]  = prim_op;
          dat_log[n_ops] = prim_wdata;
          ack_log[n_ops] = prim_ack;
        end
        n_ops++;
        if (op == 3'd3) begin
          chk(!data_ready, "R5 recv requested while data_ready", 32'(data_ready), 0);
          prim_rdata = exp_byte(rcv_i);
          rcv_i++;
        end
        if (op == 3'd2) begin
          prim_nack = (send_i == nack_at);
          send_i++;
        end
        repeat ($urandom_range(0, 2)) @(negedge clk);
        prim_done = 1'b1;
        @(negedge clk);
        prim_done = 1'b0;
        prim_nack = 1'b0;
      end
    end
  end

  task automatic check_log(input logic [6:0] a, input logic [7:0] c,
                           input int total, input int nk);
    int exp_ops;
    int stop_at;
    if (nk == 0)      stop_at = 2;
    else if (nk == 1) stop_at = 3;
    else if (nk == 2) stop_at = 5;
    else              stop_at = 5 + total;
    exp_ops = stop_at + 1;
    chk(n_ops == exp_ops, "R1 primitive count", 32'(n_ops), 32'(exp_ops));
    chk(op_log[0] == 3'd0, "R1 first op START", 32'(op_log[0]), 0);
    chk(op_log[1] == 3'd2 && dat_log[1] == {a, 1'b0}, "R1 address write",
        {op_log[1], dat_log[1]}, {3'd2, a, 1'b0});
    if (nk != 0)
      chk(op_log[2] == 3'd2 && dat_log[2] == c, "R1 command send",
          {op_log[2], dat_log[2]}, {3'd2, c});
    if (nk < 0 || nk == 2) begin
      chk(op_log[3] == 3'd1, "R1 repeated start", 32'(op_log[3]), 1);
      chk(op_log[4] == 3'd2 && dat_log[4] == {a, 1'b1}, "R1 address read",
          {op_log[4], dat_log[4]}, {3'd2, a, 1'b1});
    end
    if (nk < 0) begin
      for (int j = 0; j < total; j++) begin
        chk(op_log[5+j] == 3'd3, "R1 receive op", 32'(op_log[5+j]), 3);
        chk(ack_log[5+j] == (j != total - 1),
            pec_en ? "R3 ack/nack with check byte" : "R2 ack/nack without check byte",
            32'(ack_log[5+j]), 32'(j != total - 1));
      end
    end
    chk(op_log[stop_at] == 3'd4, nk >= 0 ? "R8 stop after refusal" : "R1 final STOP",
        32'(op_log[stop_at]), 4);
  endtask

  task automatic run_txn(input int n, input bit pec, input int nk, input bit busy_start);
    logic [6:0] a;
    logic [7:0] c;
    int total, k, waited;
    a = 7'($urandom);
    c = 8'($urandom);
    total = n + 1 + int'(pec);
    cur_n = n;
    cur_salt = int'($urandom_range(0, 255));
    n_ops = 0; send_i = 0; rcv_i = 0; nack_at = nk;
    @(negedge clk);
    slave_addr = a; tx_cmd = c; byte_count = 8'(n); pec_en = pec;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !eom && !err && !data_ready, "R9 start accepted and flags cleared",
        {busy, eom, err, data_ready}, 4'b1000);
    // inputs change after start: R9 says the run uses captured values
    slave_addr = 7'($urandom); tx_cmd = 8'($urandom); byte_count = 8'($urandom);
    k = 0;
    waited = 0;
    while (!eom && waited < 20000) begin
      if (busy_start && waited == 7) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end else
        @(negedge clk);
      waited++;
      if (data_ready && !eom) begin
        chk(rx_word == exp_word(k, total), "R4 packed word", rx_word, exp_word(k, total));
        k++;
        repeat ($urandom_range(0, 4)) begin
          @(negedge clk);
          chk(data_ready, "R5 data_ready held until cleared", 32'(data_ready), 1);
        end
        dr_clear = 1'b1;
        @(negedge clk);
        dr_clear = 1'b0;
      end
    end
    chk(eom, "R6 end of message reached", 32'(eom), 1);
    chk(!busy, "R6 idle at end of message", 32'(busy), 0);
    if (nk >= 0) begin
      chk(err, "R8 error flag", 32'(err), 1);
      chk(!data_ready && rx_count == 0, "R7 count after error",
          {data_ready, rx_count}, 0);
    end else begin
      chk(!err, "R8 no error on clean run", 32'(err), 0);
      chk(data_ready == (total % 4 == 0), "R6 data_ready with eom on full final word",
          32'(data_ready), 32'(total % 4 == 0));
      chk(rx_count == 2'(total % 4), "R7 final byte count", 32'(rx_count), 32'(total % 4));
      chk(rx_word == exp_word(k, total), "R4 final word", rx_word, exp_word(k, total));
      if (pec)
        chk(rx_word[((total - 1) % 4)*8 +: 8] == exp_byte(total - 1),
            "R3 check byte stored", rx_word[((total - 1) % 4)*8 +: 8],
            exp_byte(total - 1));
      if (data_ready) begin
        dr_clear = 1'b1;
        @(negedge clk);
        dr_clear = 1'b0;
      end
    end
    check_log(a, c, total, nk);
    repeat (2) @(negedge clk);
    chk(eom, "R6 eom holds until next start", 32'(eom), 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!prim_valid && !busy && !eom && !err && !data_ready && rx_count == 0,
        "R1 reset state", {prim_valid, busy, eom, err, data_ready, rx_count}, 0);
    run_txn(3, 1'b0, -1, 1'b0);   // R6 N=3: four bytes, eom with data_ready
    run_txn(2, 1'b1, -1, 1'b0);   // R3 total four including check byte
    run_txn(0, 1'b0, -1, 1'b0);   // R2 length byte NACKed
    run_txn(0, 1'b1, -1, 1'b0);   // R3 length ACKed, check byte NACKed
    run_txn(7, 1'b0, -1, 1'b0);   // R5 two full words
    run_txn(5, 1'b1, -1, 1'b0);   // R7 partial final word
    run_txn(4, 1'b0, 0, 1'b0);    // R8 address write refused
    run_txn(4, 1'b0, 1, 1'b0);    // R8 command refused
    run_txn(4, 1'b1, 2, 1'b0);    // R8 address read refused
    run_txn(9, 1'b0, -1, 1'b1);   // R9 start during busy ignored
    for (int t = 0; t < 25; t++)
      run_txn(int'($urandom_range(0, 40)), 1'($urandom), -1,
              ($urandom_range(0, 3) == 0));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule